// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block tests a small single-port synchronous RAM without help from outside. A one-cycle `start` pulse launches a fixed series of write and read operations. The series has three parts. First a solid background of zeros and then ones is written and read. Next a single set bit, and then a single cleared bit, walks through every word. Last, each address in turn acts as a base cell while every other address is read around it. The block drives the RAM address, write enable and write data itself.

Each read response arrives one cycle after the read is issued. The block compares it against the word the sequence expects, and any mismatch is held until the run ends. Every response is also folded into a shift-and-feedback signature register. A test host can therefore match the final signature against a golden value as well as reading the pass flag. The RAM itself stays outside the block.

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is held and until the first accepted start, busy, done, pass and mem_we are low and signature is zero.
- R2: A start sampled while idle begins a run. Operation k (counting from 0) appears on the RAM port k+1 cycles after that start edge. The total is NOPS = 5*D + 4*D*W + 2*D*D operations, where D = 2^ADDR_W and W = DATA_W. Done is high for exactly one cycle, NOPS+2 cycles after the start edge. Busy is high in every cycle from the first operation through the cycle before done, and is low when done is high.
- R3: The solid part runs four passes, each in ascending address order: write all-zeros to every address, read every address expecting all-zeros, write all-ones to every address, and read every address expecting all-ones.
- R4: The walking part first uses a word with only bit b set. For each address in ascending order and each bit b from 0 up, it writes that word and reads it back at once. It then repeats the same order with the bitwise complement of that word.
- R5: The galloping part first writes zero to every address in ascending order. Then, for each base address B in ascending order, it writes all-ones to B. It then steps through the other addresses from B+1, wrapping modulo D, and for each one reads that address expecting zero and then reads B expecting all-ones. It ends the base by writing zero back to B.
- R6: Each read response is compared with its expected word in the cycle after the read is issued. Pass is high together with done only if no response in the run differed. Pass is low whenever done is low. A new start clears any earlier mismatch.
- R7: Signature is cleared by an accepted start. For each read response d, in order, it becomes (sig<<1) XOR (POLY if the old sig MSB was 1, else 0) XOR d, with d zero-extended. It holds its value after done until the next start.
- R8: A start pulse during a run has no effect: the operation stream, done timing, pass and signature are the same as in a run without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launches a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | High with done when every read matched |
| signature | output | SIG_W | Compacted read responses |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the read |

## Verification
The bench runs the sequence against a fault-free RAM and checks the exact operation stream, the done timing, a set pass flag and a signature computed from the expected read words. Stuck-at cells at random addresses, bits and polarities, plus one at the highest address and top bit, must clear pass and give the signature the faulty responses predict, which shows that both the compare and the compaction see the bad bit. A coupling fault is triggered only by writing an all-ones word to one address. The solid and walking parts miss it, so it exposes only the galloping part. A stray start during a run and a clean run after a failing one confirm that the run ignores extra starts and that each start clears the earlier results.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_SOLID_W, PH_SOLID_R, PH_WALK_W, PH_WALK_R,
    PH_GAL_INIT, PH_GAL_BASE, PH_GAL_RO, PH_GAL_RB, PH_GAL_RST,
    PH_FINISH, PH_REPORT
  } mbist_ph_e;
endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              clear,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_en,
  output logic [DATA_W-1:0] rd_exp
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [ADDR_W-1:0] A_LAST = '1;
  localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);
  localparam logic [BIT_W-1:0]  B_LAST = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0]  B_ONE  = BIT_W'(1);
  localparam logic [DATA_W-1:0] ONES   = '1;

  mbist_ph_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, oth_q, oth_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              flg_q, flg_d;
  logic [ADDR_W-1:0] addr_inc, oth_inc;
  logic [DATA_W-1:0] walk_pat;

  assign addr_inc = addr_q + A_ONE;
  assign oth_inc  = oth_q + A_ONE;
  assign walk_pat = flg_q ? ~(DATA_W'(1) << bit_q) : (DATA_W'(1) << bit_q);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    oth_d  = oth_q;
    bit_d  = bit_q;
    flg_d  = flg_q;
    case (st_q)
      PH_IDLE: if (start) begin
        st_d = PH_SOLID_W; addr_d = '0; flg_d = 1'b0; bit_d = '0;
      end
      PH_SOLID_W: begin
        addr_d = addr_inc;
        if (addr_q == A_LAST) st_d = PH_SOLID_R;
      end
      PH_SOLID_R: begin
        addr_d = addr_inc;
        if (addr_q == A_LAST) begin
          flg_d = ~flg_q;
          st_d  = flg_q ? PH_WALK_W : PH_SOLID_W;
        end
      end
      PH_WALK_W: st_d = PH_WALK_R;
      PH_WALK_R: begin
        st_d = PH_WALK_W;
        if (bit_q == B_LAST) begin
          bit_d  = '0;
          addr_d = addr_inc;
          if (addr_q == A_LAST) begin
            flg_d = ~flg_q;
            if (flg_q) st_d = PH_GAL_INIT;
          end
        end else begin
          bit_d = bit_q + B_ONE;
        end
      end
      PH_GAL_INIT: begin
        addr_d = addr_inc;
        if (addr_q == A_LAST) st_d = PH_GAL_BASE;
      end
      PH_GAL_BASE: begin
        oth_d = addr_inc;
        st_d  = PH_GAL_RO;
      end
      PH_GAL_RO: st_d = PH_GAL_RB;
      PH_GAL_RB: begin
        if (oth_inc == addr_q) begin
          st_d = PH_GAL_RST;
        end else begin
          oth_d = oth_inc;
          st_d  = PH_GAL_RO;
        end
      end
      PH_GAL_RST: begin
        addr_d = addr_inc;
        st_d   = (addr_q == A_LAST) ? PH_FINISH : PH_GAL_BASE;
      end
      PH_FINISH: st_d = PH_REPORT;
      PH_REPORT: st_d = PH_IDLE;
      default:   st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      addr_q <= '0;
      oth_q  <= '0;
      bit_q  <= '0;
      flg_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      oth_q  <= oth_d;
      bit_q  <= bit_d;
      flg_q  <= flg_d;
    end
  end

  always_comb begin
    mem_addr  = addr_q;
    mem_we    = 1'b0;
    mem_wdata = '0;
    rd_en     = 1'b0;
    rd_exp    = '0;
    case (st_q)
      PH_SOLID_W:  begin mem_we = 1'b1; mem_wdata = {DATA_W{flg_q}}; end
      PH_SOLID_R:  begin rd_en = 1'b1; rd_exp = {DATA_W{flg_q}}; end
      PH_WALK_W:   begin mem_we = 1'b1; mem_wdata = walk_pat; end
      PH_WALK_R:   begin rd_en = 1'b1; rd_exp = walk_pat; end
      PH_GAL_INIT: mem_we = 1'b1;
      PH_GAL_BASE: begin mem_we = 1'b1; mem_wdata = ONES; end
      PH_GAL_RO:   begin rd_en = 1'b1; mem_addr = oth_q; end
      PH_GAL_RB:   begin rd_en = 1'b1; rd_exp = ONES; end
      PH_GAL_RST:  mem_we = 1'b1;
      default:     ;
    endcase
  end

  assign busy  = (st_q != PH_IDLE) && (st_q != PH_REPORT);
  assign done  = (st_q == PH_REPORT);
  assign clear = (st_q == PH_IDLE) && start;

  // R5: while galloping, the neighbour read never lands on the base cell
  assert_gallop_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_GAL_RO) |-> (mem_addr != addr_q));
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cap,
  output logic              fail
);
  logic [DATA_W-1:0] exp_q;
  logic              rd_q;
  logic              miss;

  assign miss = rd_q && (mem_rdata != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      exp_q <= '0;
      fail  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (rd_en) exp_q <= rd_exp;
      if (clear)     fail <= 1'b0;
      else if (miss) fail <= 1'b1;
    end
  end

  assign cap = rd_q;

  // R6: a differing response in its compare cycle leaves the sticky flag set
  assert_miss_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && (mem_rdata != exp_q) && !clear) |=> fail);
endmodule

// File: rtl/mbist_misr.sv
module mbist_misr #(
  parameter int              DATA_W = 4,
  parameter int              SIG_W  = 16,
  parameter logic [SIG_W-1:0] POLY  = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap,
  input  logic [DATA_W-1:0] din,
  output logic [SIG_W-1:0]  sig
);
  logic [SIG_W-1:0] fb, sig_next;

  assign fb       = sig[SIG_W-1] ? POLY : '0;
  assign sig_next = {sig[SIG_W-2:0], 1'b0} ^ fb ^ SIG_W'(din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (cap)   sig <= sig_next;
  end

  // R7: without a response or a start the signature keeps its value
  assert_sig_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !clear) |=> $stable(sig));
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int               ADDR_W = 3,
  parameter int               DATA_W = 4,
  parameter int               SIG_W  = 16,
  parameter logic [SIG_W-1:0] POLY   = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [SIG_W-1:0]  signature,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              clear, rd_en, cap, fail;
  logic [DATA_W-1:0] rd_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .start(start), .busy(busy), .done(done),
    .clear(clear), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .rd_en(rd_en), .rd_exp(rd_exp)
  );

  mbist_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_core_n), .clear(clear), .rd_en(rd_en),
    .rd_exp(rd_exp), .mem_rdata(mem_rdata), .cap(cap), .fail(fail)
  );

  mbist_misr #(.DATA_W(DATA_W), .SIG_W(SIG_W), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_core_n), .clear(clear), .cap(cap),
    .din(mem_rdata), .sig(signature)
  );

  assign pass = done && !fail;

  // R2: done lasts a single cycle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |=> !done);
  // R8: a run only begins from a start pulse
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(busy) |-> $past(start));
  // R6: pass never shows outside the done cycle
  assert_pass_with_done_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    pass |-> done);
endmodule

// File: tb/mbist_ctrl_tb.sv
module mbist_ctrl_tb;
  localparam int AW = 3;
  localparam int DW = 4;
  localparam int SW = 16;
  localparam logic [SW-1:0] POLY = 16'h1021;
  localparam int D = 1 << AW;
  localparam int NOPS = 5*D + 4*D*DW + 2*D*D;

  logic clk = 1'b0;
  logic rst_n, start, busy, done, pass, mem_we;
  logic [SW-1:0] signature;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SIG_W(SW), .POLY(POLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .signature(signature), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model with injectable faults: 1 = stuck bit, 2 = write-ones coupling
  logic [DW-1:0] ram [D];
  int flt_kind, fa, fb, cp_src, cp_dst;
  bit fv;

  function automatic logic [DW-1:0] apply_stuck(logic [DW-1:0] v, int a);
    logic [DW-1:0] r = v;
    if (flt_kind == 1 && a == fa) r[fb] = fv;
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
      if (flt_kind == 2 && int'(mem_addr) == cp_src && mem_wdata == {DW{1'b1}})
        ram[cp_dst][0] <= 1'b1;
    end
    mem_rdata <= apply_stuck(ram[mem_addr], int'(mem_addr));
  end

  bit            op_we [NOPS];
  logic [AW-1:0] op_a  [NOPS];
  logic [DW-1:0] op_d  [NOPS];
  int nop;
  int checks = 0, fails = 0;

  task automatic add(bit we, int a, logic [DW-1:0] d);
    op_we[nop] = we; op_a[nop] = AW'(a); op_d[nop] = d; nop++;
  endtask

  task automatic build_ops;
    nop = 0;
    for (int bg = 0; bg < 2; bg++) begin
      for (int a = 0; a < D; a++) add(1, a, {DW{bg[0]}});
      for (int a = 0; a < D; a++) add(0, a, {DW{bg[0]}});
    end
    for (int inv = 0; inv < 2; inv++)
      for (int a = 0; a < D; a++)
        for (int b = 0; b < DW; b++) begin
          logic [DW-1:0] p = DW'(1) << b;
          if (inv == 1) p = ~p;
          add(1, a, p); add(0, a, p);
        end
    for (int a = 0; a < D; a++) add(1, a, '0);
    for (int b = 0; b < D; b++) begin
      add(1, b, '1);
      for (int k = 1; k < D; k++) begin
        add(0, (b + k) % D, '0); add(0, b, '1);
      end
      add(1, b, '0);
    end
  endtask

  function automatic logic [SW-1:0] model_sig(bit stuck);
    logic [SW-1:0] s = '0;
    for (int i = 0; i < NOPS; i++)
      if (!op_we[i]) begin
        logic [DW-1:0] d = op_d[i];
        if (stuck && int'(op_a[i]) == fa) d[fb] = fv;
        s = {s[SW-2:0], 1'b0} ^ (s[SW-1] ? POLY : '0) ^ SW'(d);
      end
    return s;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // caller is at a negedge
  task automatic run(string tag, int glitch_at, bit exp_pass, bit chk_sig,
                     logic [SW-1:0] exp_sig);
    int cyc = 0, op_err = 0, busy_err = 0, done_cyc = -1;
    bit got_pass = 0;
    logic [SW-1:0] got_sig = '0;
    start = 1'b1;
    while (done_cyc < 0 && cyc < NOPS + 20) begin
      @(negedge clk);
      cyc++;
      start = (cyc == glitch_at);
      if (cyc <= NOPS) begin
        if (mem_we !== op_we[cyc-1] || mem_addr !== op_a[cyc-1]) op_err++;
        else if (op_we[cyc-1] && mem_wdata !== op_d[cyc-1]) op_err++;
      end
      if (cyc <= NOPS + 1 && busy !== 1'b1) busy_err++;
      if (done === 1'b1) begin
        done_cyc = cyc; got_pass = pass; got_sig = signature;
        chk(busy === 1'b0, "R2", {tag, " busy low at done"}, busy, 0);
      end
    end
    start = 1'b0;
    chk(op_err == 0, "R3/R4/R5", {tag, " operation stream errors"}, op_err, 0);
    chk(busy_err == 0, "R2", {tag, " busy gaps"}, busy_err, 0);
    chk(done_cyc == NOPS + 2, "R2", {tag, " done cycle"}, done_cyc, NOPS + 2);
    chk(got_pass == exp_pass, "R6", {tag, " pass"}, got_pass, exp_pass);
    if (chk_sig) chk(got_sig == exp_sig, "R7", {tag, " signature"}, got_sig, exp_sig);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && pass === 1'b0, "R2",
        {tag, " single done pulse"}, {done, busy, pass}, 0);
    chk(signature == got_sig, "R7", {tag, " signature held"}, signature, got_sig);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [SW-1:0] golden;
    rst_n = 1'b0; start = 1'b0; flt_kind = 0; fa = 0; fb = 0; fv = 0;
    cp_src = 0; cp_dst = 0;
    for (int i = 0; i < D; i++) ram[i] = '0;
    build_ops();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && pass === 0 && mem_we === 0 && signature === '0,
        "R1", "reset state", {busy, done, pass, mem_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 0 && mem_we === 0 && signature === '0, "R1", "idle after reset",
        {busy, mem_we}, 0);

    golden = model_sig(0);
    run("clean", 0, 1, 1, golden);
    run("stray start", 120, 1, 1, golden);   // R8

    for (int t = 0; t < 4; t++) begin
      flt_kind = 1;
      fa = int'($urandom % D); fb = int'($urandom % DW); fv = bit'($urandom % 2);
      run("random stuck cell", 0, 0, 1, model_sig(1));
    end
    flt_kind = 1; fa = D - 1; fb = DW - 1; fv = 1;
    run("top cell stuck high", 0, 0, 1, model_sig(1));

    flt_kind = 2; cp_src = D - 1; cp_dst = 1;
    run("coupling", 0, 0, 0, '0);

    flt_kind = 0;
    run("clean after fail", 0, 1, 1, golden);  // R6 and R7 cleared by start

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule